// File: doc/BRIEF.md
# Successive-Approximation Frequency Tracker

This block measures the period of a digital input by tuning an internal phase accumulator until its rate matches the input. The accumulator adds a tuning word to itself on every system clock. Every trial runs over exactly one input period. The accumulator is cleared on an input rising edge, and the block then records whether it carries out before the next rising edge is processed.

The tuning word is settled one bit per input period, starting at the most significant bit. Each bit is first set on a trial basis. If the accumulator overran during that period, the oscillator ran faster than the input, so the bit is cleared. Otherwise the bit stays set.

Once every bit has been decided, the block raises a lock flag and freezes the word until software issues a new start. A programmable limit on the wait between input edges stops a search when the input goes quiet. In that case the block raises an error flag instead of a lock.

A user pulses `start`, waits for `locked` or `timed_out`, and reads `tune_word`. For a steady input period of P clocks, the locked word is the largest value whose accumulator does not wrap within P clocks. Later frequency arithmetic is left to the consumer.

Top module: `sar_freq_tracker`

## Requirements
- R1: After reset, `tune_word` is 0, and `locked` and `timed_out` are both 0.
- R2: A `start` pulse, in any state, restarts the search. On the next clock `tune_word` is 0, and `locked` and `timed_out` are both 0. The block then waits for an input rising edge.
- R3: The input passes through a two-flop synchronizer. A rising edge whose first high sample is taken at clock edge n is acted on at clock edge n+2, and never earlier.
- R4: The first processed rising edge after `start` begins the first trial from zero phase. At that edge `tune_word` becomes 2^(WORD_W-1), which is the MSB tentatively set. Each later edge decides one bit, most significant first, and sets the next lower bit tentatively. `tune_word` never gains more than one set bit per clock.
- R5: A trial bit is cleared when the accumulator carries out on or before the clock that processes the closing edge. Otherwise it is kept. For a steady input period of P clocks, the locked word equals floor((2^WORD_W - 1) / P).
- R6: `locked` rises on the processed edge that decides bit 0, which is WORD_W+1 processed edges after start. While `locked` is high and no `start` arrives, `tune_word` and `locked` stay unchanged whatever the input does.
- R7: During a search, the counter restarts at 0 on `start` and on each processed edge. If it reaches `edge_timeout` with no edge, the search stops on the next clock and `timed_out` rises, with `locked` low. `timed_out` then holds until `start`.
- R8: `locked` and `timed_out` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_in | input | 1 | Asynchronous input whose frequency is tracked |
| start | input | 1 | One-clock pulse that begins a new search |
| edge_timeout | input | TMO_W | Most clocks allowed between processed input edges |
| tune_word | output | WORD_W | Tuning word, tentative during search and final once locked |
| locked | output | 1 | All bits decided and word frozen |
| timed_out | output | 1 | Search abandoned for lack of input edges |

## Verification
The assertions assume that `start` is a single-clock pulse, sampled synchronously. They also assume that `edge_timeout` does not change while a search runs. The bench therefore drives `start` and `edge_timeout` only on falling clock edges, and alters the timeout only between searches. The input waveform is generated with high and low phases of at least one clock each, so every period carries a rising edge that the synchronizer can see. Periods are chosen below the programmed timeout, except in the cases that deliberately silence the input to reach the error path.

// File: rtl/sar_freq_tracker_pkg.sv
// Package: shared types for the successive-approximation frequency tracker.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package sar_freq_tracker_pkg;

    // Search controller states.
    typedef enum logic [1:0] {
        TRK_IDLE  = 2'd0,   // finished, aborted or never started
        TRK_ARM   = 2'd1,   // waiting for the edge that opens the first trial
        TRK_TRIAL = 2'd2    // one trial in progress, bit under test set
    } trk_state_t;

endpackage

// File: rtl/sar_edge_sync.sv
// Module: two-flop synchronizer followed by a rising-edge detector.
// Assumes sig_in is asynchronous to clk. Its high and low phases must each
// last at least one clock, or an edge can be lost.
module sar_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise
);
    logic meta_q, sync_q, prev_q;

    // Shift the input through the metastability stages and keep one older sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= sig_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // A new high synchronized sample after a low one marks a rising edge.
    always_comb rise = sync_q & ~prev_q;
endmodule

// File: rtl/sar_phase_acc.sv
// Module: phase accumulator with synchronous clear and combinational carry-out.
// Assumes step is stable during a trial. clr takes priority over en.
module sar_phase_acc #(
    parameter int W = 28
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] step,
    output logic         carry
);
    logic [W-1:0] phase_q;
    logic [W:0]   sum;

    // Widened sum exposes the wrap of this clock's addition.
    always_comb begin
        sum   = {1'b0, phase_q} + {1'b0, step};
        carry = en & sum[W];
    end

    // Restart from zero phase on clr, otherwise advance while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) phase_q <= '0;
        else if (en)       phase_q <= sum[W-1:0];
    end
endmodule

// File: rtl/sar_edge_timer.sv
// Module: counts clocks since the last processed edge and flags expiry.
// Assumes limit is held steady during a search. expired is suppressed
// in a cycle that also clears the count.
module sar_edge_timer #(
    parameter int TW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    // Expiry when the count has reached the limit with no clearing event.
    always_comb expired = en & ~clr & (cnt_q == limit);

    // Clear on an event, otherwise count while a search is active.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else if (en)       cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/sar_freq_tracker.sv
// Module: top of the frequency tracker. A successive-approximation controller
// tunes a phase accumulator so that one input period holds as many
// accumulator steps as possible without a wrap.
// Assumes start is a one-clock pulse and edge_timeout is steady during a search.
module sar_freq_tracker #(
    parameter int WORD_W = 28,
    parameter int TMO_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sig_in,
    input  logic              start,
    input  logic [TMO_W-1:0]  edge_timeout,
    output logic [WORD_W-1:0] tune_word,
    output logic              locked,
    output logic              timed_out
);
    import sar_freq_tracker_pkg::*;

    localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WORD_W - 1);

    trk_state_t        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic              wrapped_q;
    logic              rise, carry, expired, early, busy, evt_clr;
    logic [WORD_W-1:0] mask, word_dec;

    sar_edge_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (sig_in),
        .rise   (rise)
    );

    sar_phase_acc #(.W(WORD_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (evt_clr),
        .en    (state_q == TRK_TRIAL),
        .step  (tune_word),
        .carry (carry)
    );

    sar_edge_timer #(.TW(TMO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (evt_clr),
        .en      (busy),
        .limit   (edge_timeout),
        .expired (expired)
    );

    // Decision terms: bit under test and the word after deciding it.
    always_comb begin
        busy     = (state_q != TRK_IDLE);
        evt_clr  = start | rise;
        mask     = WORD_W'(1) << idx_q;
        early    = wrapped_q | carry;
        word_dec = early ? (tune_word & ~mask) : tune_word;
        if (idx_q != '0) word_dec = word_dec | (mask >> 1);
    end

    // Search controller: arm, one trial per input period, lock or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= TRK_IDLE;
            idx_q     <= '0;
            wrapped_q <= 1'b0;
            tune_word <= '0;
            locked    <= 1'b0;
            timed_out <= 1'b0;
        end else if (start) begin
            state_q   <= TRK_ARM;
            idx_q     <= TOP_IDX;
            wrapped_q <= 1'b0;
            tune_word <= '0;
            locked    <= 1'b0;
            timed_out <= 1'b0;
        end else begin
            case (state_q)
                TRK_ARM: begin
                    if (rise) begin
                        tune_word <= tune_word | mask;
                        wrapped_q <= 1'b0;
                        state_q   <= TRK_TRIAL;
                    end else if (expired) begin
                        timed_out <= 1'b1;
                        state_q   <= TRK_IDLE;
                    end
                end
                TRK_TRIAL: begin
                    if (rise) begin
                        tune_word <= word_dec;
                        wrapped_q <= 1'b0;
                        if (idx_q == '0) begin
                            locked  <= 1'b1;
                            state_q <= TRK_IDLE;
                        end else begin
                            idx_q <= idx_q - 1'b1;
                        end
                    end else if (expired) begin
                        timed_out <= 1'b1;
                        state_q   <= TRK_IDLE;
                    end else begin
                        wrapped_q <= wrapped_q | carry;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sar_freq_tracker_chk.sv
// Module: property checker for the frequency tracker, attached by bind.
// Assumes start is sampled synchronously and reset is active low.
module sar_freq_tracker_chk #(
    parameter int WORD_W = 28
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [WORD_W-1:0] tune_word,
    input logic              locked,
    input logic              timed_out
);
    // R2: a start clears the word and both flags on the next clock.
    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (tune_word == '0 && !locked && !timed_out));

    // R4: at most one new set bit per clock.
    a_r4_one_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tune_word & ~$past(tune_word)) <= 1);

    // R6: a locked word is frozen until the next start.
    a_r6_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !start) |=> (locked && $stable(tune_word)));

    // R7: an abort is sticky until the next start.
    a_r7_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (timed_out && !start) |=> timed_out);

    // R8: lock and abort are mutually exclusive.
    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(locked && timed_out));
endmodule

bind sar_freq_tracker sar_freq_tracker_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .tune_word (tune_word),
    .locked    (locked),
    .timed_out (timed_out)
);

// File: tb/sim_sar_freq_tracker.sv
module sim_sar_freq_tracker;
    localparam int WW = 28;
    localparam int TW = 20;
    localparam longint TWO_W = longint'(1) << WW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sig_in = 1'b0;
    logic          start = 1'b0;
    logic [TW-1:0] edge_timeout = TW'(5000);
    logic [WW-1:0] tune_word;
    logic          locked, timed_out;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit gen_on = 1'b0;
    int hi_len = 1, lo_len = 1;

    // Behavioural reference state.
    int     m_st = 0;            // 0 idle, 1 arm, 2 trial
    longint m_word = 0, m_acc = 0;
    int     m_idx = 0, m_cnt = 0;
    bit     m_lk = 0, m_er = 0, m_wr = 0;
    bit     hist[$] = '{0, 0, 0};   // hist[0] newest sample

    sar_freq_tracker #(.WORD_W(WW), .TMO_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .start(start),
        .edge_timeout(edge_timeout), .tune_word(tune_word),
        .locked(locked), .timed_out(timed_out)
    );

    always #10 clk = ~clk;   // 50 MHz

    // Input waveform generator, driven on falling edges.
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            if (gen_on) begin
                ph = ph + 1;
                if (ph >= hi_len + lo_len) ph = 0;
                sig_in = (ph < hi_len);
            end else begin
                ph = 0;
                sig_in = 1'b0;
            end
        end
    end

    // Reference model, advanced on every rising edge (R3, R4, R5, R7).
    always @(posedge clk) begin
        bit r, clr, cy, expd, early;
        longint sum, mask;
        int st_old;
        cyc = cyc + 1;
        r = hist[1] && !hist[2];
        if (!rst_n) begin
            m_st = 0; m_word = 0; m_acc = 0; m_idx = 0; m_cnt = 0;
            m_lk = 0; m_er = 0; m_wr = 0;
            hist = '{0, 0, 0};
        end else begin
            st_old = m_st;
            clr  = start || r;
            sum  = m_acc + m_word;
            cy   = (st_old == 2) && (sum >= TWO_W);
            expd = (st_old != 0) && !clr && (m_cnt == int'(edge_timeout));
            mask = longint'(1) << m_idx;
            if (start) begin
                m_st = 1; m_idx = WW - 1; m_word = 0; m_lk = 0; m_er = 0; m_wr = 0;
            end else if (st_old == 1) begin
                if (r) begin m_word = m_word + mask; m_wr = 0; m_st = 2; end
                else if (expd) begin m_er = 1; m_st = 0; end
            end else if (st_old == 2) begin
                if (r) begin
                    early = m_wr || cy;
                    if (early) m_word = m_word - mask;
                    m_wr = 0;
                    if (m_idx == 0) begin m_lk = 1; m_st = 0; end
                    else begin m_idx = m_idx - 1; m_word = m_word + mask / 2; end
                end else if (expd) begin m_er = 1; m_st = 0; end
                else m_wr = m_wr || cy;
            end
            if (clr) m_acc = 0;
            else if (st_old == 2) m_acc = sum % TWO_W;
            if (clr) m_cnt = 0;
            else if (st_old != 0) m_cnt = (m_cnt + 1) % (1 << TW);
            hist.push_front(sig_in);
            void'(hist.pop_back());
        end
    end

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (cyc > 0) begin
            checks = checks + 1;
            if (longint'(tune_word) != m_word || locked != m_lk || timed_out != m_er) begin
                fails = fails + 1;
                $display("FAIL R3/R4/R5/R7 cycle model at %0d: word=%0d lk=%0b to=%0b expected word=%0d lk=%0b to=%0b",
                         cyc, tune_word, locked, timed_out, m_word, m_lk, m_er);
            end
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(tune_word == '0 && !locked && !timed_out, "R2 start clears", longint'(tune_word), 0);
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Run one search at a steady period and verify the outcome.
    task automatic lock_run(input int hi, input int lo, input bit restart_mid);
        int p = hi + lo;
        int guard;
        longint exp_w = (TWO_W - 1) / p;
        longint held;
        hi_len = hi; lo_len = lo; gen_on = 1'b1;
        pulse_start();
        if (restart_mid) begin
            wait_cycles(5 * p);
            pulse_start();
        end
        guard = 0;
        while (tune_word == '0 && guard < 4 * p + 20) begin @(negedge clk); guard++; end
        check(longint'(tune_word) == (TWO_W >> 1), "R4 first trial MSB", longint'(tune_word), TWO_W >> 1);
        guard = 0;
        while (!locked && !timed_out && guard < (WW + 3) * p + 50) begin @(negedge clk); guard++; end
        check(locked == 1'b1, "R6 lock reached", longint'(locked), 1);
        check(timed_out == 1'b0, "R8 no error with lock", longint'(timed_out), 0);
        check(longint'(tune_word) == exp_w, "R5 locked word", longint'(tune_word), exp_w);
        held = longint'(tune_word);
        hi_len = 2; lo_len = 3;
        wait_cycles(200);
        check(longint'(tune_word) == held && locked, "R6 word held after lock", longint'(tune_word), held);
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        wait (cyc >= 190000);
        fails = fails + 1;
        $display("FAIL watchdog expired: actual=%0d cycles expected=<190000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait_cycles(5);
        check(tune_word == '0 && !locked && !timed_out, "R1 reset state", longint'(tune_word), 0);
        @(negedge clk); rst_n = 1'b1;
        wait_cycles(3);
        check(tune_word == '0 && !locked && !timed_out, "R1 idle after reset", longint'(tune_word), 0);

        lock_run(3, 4, 1'b0);     // P=7
        lock_run(1, 1, 1'b0);     // P=2, carry exactly on the edge
        lock_run(1, 2, 1'b0);     // P=3
        lock_run(1, 12, 1'b0);    // P=13, narrow pulse
        lock_run(10, 10, 1'b1);   // P=20, restart mid-search (R2)
        lock_run(500, 500, 1'b0); // P=1000

        // R7: silent input while armed.
        gen_on = 1'b0;
        edge_timeout = TW'(40);
        pulse_start();
        wait_cycles(30);
        check(timed_out == 1'b0, "R7 no early abort", longint'(timed_out), 0);
        wait_cycles(30);
        check(timed_out == 1'b1 && !locked, "R7 abort while armed", longint'(timed_out), 1);
        wait_cycles(100);
        check(timed_out == 1'b1, "R7 abort sticky", longint'(timed_out), 1);

        // R7: input stops in the middle of a search.
        hi_len = 3; lo_len = 4; gen_on = 1'b1;
        pulse_start();
        wait_cycles(40);
        gen_on = 1'b0;
        wait_cycles(100);
        check(timed_out == 1'b1 && !locked, "R7 abort mid-search", longint'(timed_out), 1);

        // R2: start after an abort recovers to a clean lock.
        edge_timeout = TW'(5000);
        lock_run(4, 5, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule